// File: doc/BRIEF.md
# Flash read-data selector

This block forms the word returned on every read of a parallel NOR flash. The command decoder next to it supplies a mode code, and the selector picks what goes back on the bus: plain storage contents, identification words, a status byte whose bits toggle so software can poll a running operation, or entries from an external query parameter table.

The block also keeps the status byte. Program and erase start events load it. A completion event flips its top bit. Every status read flips bit 6 once the returned value has been captured. Read data is registered and appears one clock after the read strobe. It then holds until the next strobe.

Top module: `flash_read_mux`

## Requirements
- R1: After reset `rd_data` is 0 and the status byte is 0, so the first status read returns 0x00.
- R2: The table index is `rd_off` shifted right by log2(DATA_W/8); for 16-bit width, offset 0x1C addresses index 0x0E. `qry_addr` always shows this index.
- R3: Mode codes 0 (array), 1 (erase setup) and the unused codes 5, 6 and 7 return `arr_data`.
- R4: In mode 2 (identify), index 0 returns MFR_ID, index 1 returns DEV_ID and index 2 returns 0.
- R5: In mode 2, indices 0x0E and 0x0F return XID2 and XID3. If that word is all ones, the read returns `arr_data`. Every other index also returns `arr_data`.
- R6: In mode 3 (busy), a read returns the status byte zero-extended. After the value is captured, status bit 6 is inverted, so two back-to-back reads differ in bit 6.
- R7: `erase_start` sets the status byte to 0x00 and has priority over all other events.
- R8: `prog_start` sets the status byte to {~prog_d7, 7'h7F} unless `erase_start` is also high.
- R9: `op_done` inverts status bit 7. If it coincides with a busy read, both bit 7 and bit 6 flip.
- R10: In mode 4 (query), an index greater than TBL_LEN returns 0. Any other index returns `qry_data` zero-extended.
- R11: `rd_data` changes only on the clock edge that samples `rd_en` high, and does so exactly one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_off | input | 8 | Low byte of the read byte offset |
| mode | input | 3 | Mode code from the command decoder |
| arr_data | input | DATA_W | Storage array data at the read offset |
| prog_start | input | 1 | Program operation starts |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| erase_start | input | 1 | Sector or chip erase starts |
| op_done | input | 1 | Running operation completed |
| qry_addr | output | 8 | Index into the external query table |
| qry_data | input | 8 | Query table entry at `qry_addr` |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench goes after the index shift at the identify and query offsets. A wrong shift returns the identification words at the wrong addresses. It also probes the all-ones extended ID word, where a design without the sentinel check would return 0xFFFF instead of array data. The query boundary at exactly TBL_LEN and at TBL_LEN+1 catches an off-by-one in the range compare. Back-to-back status reads, and a completion that lands in the same cycle as a read, catch a toggle applied before capture or a flip that gets lost.

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
  parameter int          DATA_W  = 16,
  parameter logic [7:0]  TBL_LEN = 8'h52,
  parameter logic [15:0] MFR_ID  = 16'h0001,
  parameter logic [15:0] DEV_ID  = 16'h227E,
  parameter logic [15:0] XID2    = 16'h2201,
  parameter logic [15:0] XID3    = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [7:0]        rd_off,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              prog_start,
  input  logic              prog_d7,
  input  logic              erase_start,
  input  logic              op_done,
  output logic [7:0]        qry_addr,
  input  logic [7:0]        qry_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SH = (DATA_W == 32) ? 2 : (DATA_W == 16) ? 1 : 0;
  localparam logic [2:0] M_ID = 3'd2, M_BUSY = 3'd3, M_QRY = 3'd4;

  logic [7:0]        idx;
  logic [7:0]        stat;
  logic [DATA_W-1:0] word;
  logic              busy_rd;

  assign idx      = rd_off >> SH;
  assign qry_addr = idx;
  assign busy_rd  = rd_en && (mode == M_BUSY);

  always_comb begin
    word = arr_data;
    case (mode)
      M_ID: case (idx)
        8'h00: word = DATA_W'(MFR_ID);
        8'h01: word = DATA_W'(DEV_ID);
        8'h02: word = '0;
        8'h0E: if (XID2 != 16'hFFFF) word = DATA_W'(XID2);
        8'h0F: if (XID3 != 16'hFFFF) word = DATA_W'(XID3);
        default: ;
      endcase
      M_BUSY: word = DATA_W'(stat);
      M_QRY:  word = (idx > TBL_LEN) ? '0 : DATA_W'(qry_data);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           stat <= 8'h00;
    else if (erase_start) stat <= 8'h00;
    else if (prog_start)  stat <= {~prog_d7, 7'h7F};
    else                  stat <= stat ^ {op_done, busy_rd, 6'b0};

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R6
  toggle_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rd && !erase_start && !prog_start |=> stat[6] != $past(stat[6]));
  // R7
  erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> stat == 8'h00);
  // R9
  done_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && !erase_start && !prog_start |=> stat[7] != $past(stat[7]));
  // R10
  query_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode == M_QRY && idx > TBL_LEN |=> rd_data == '0);
endmodule

// File: tb/flash_read_mux_test.sv
module flash_read_mux_test;
  logic clk = 0, rst_n = 0, rd_en = 0, prog_start = 0, prog_d7 = 0, erase_start = 0, op_done = 0;
  logic [7:0] rd_off = 0, qry_addr, qry_data;
  logic [2:0] mode = 0;
  logic [15:0] arr_data = 0, rd_data;
  int checks = 0, errors = 0;
  logic [7:0] st = 0;
  logic [15:0] hold = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] tbl(input logic [7:0] i);
    case (i)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      default: return i ^ 8'hA5;
    endcase
  endfunction
  assign qry_data = tbl(qry_addr);

  flash_read_mux uut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_off(rd_off), .mode(mode),
    .arr_data(arr_data), .prog_start(prog_start), .prog_d7(prog_d7), .erase_start(erase_start),
    .op_done(op_done), .qry_addr(qry_addr), .qry_data(qry_data), .rd_data(rd_data));

  function automatic logic [15:0] expect_word(input logic [2:0] m, input logic [7:0] off,
                                              input logic [15:0] arr, input logic [7:0] s);
    logic [7:0] i = off >> 1;
    case (m)
      3'd2: case (i)
        8'h00: return 16'h0001;
        8'h01: return 16'h227E;
        8'h02: return 16'h0000;
        8'h0E: return 16'h2201;
        default: return arr;
      endcase
      3'd3: return {8'h00, s};
      3'd4: return (i > 8'h52) ? 16'h0000 : {8'h00, tbl(i)};
      default: return arr;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input bit rd, input logic [2:0] m, input logic [7:0] off,
                      input logic [15:0] arr, input bit ps, input bit d7, input bit es, input bit dn);
    rd_en = rd; mode = m; rd_off = off; arr_data = arr;
    prog_start = ps; prog_d7 = d7; erase_start = es; op_done = dn;
    if (rd) hold = expect_word(m, off, arr, st);
    if (es) st = 8'h00;
    else if (ps) st = {~d7, 7'h7F};
    else st = st ^ {dn, rd && m == 3'd3, 6'b0};
    @(negedge clk);
    if (rd) begin
      chk(req, rd_data, hold);
      if (m == 3'd4) chk("R2 qry_addr", {8'h00, qry_addr}, {8'h00, off >> 1});
    end else chk("R11 hold", rd_data, hold);
    rd_en = 0; prog_start = 0; erase_start = 0; op_done = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", rd_data, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    step("R1 first status", 1, 3'd3, 8'h00, 16'h1234, 0, 0, 0, 0);
    step("R6 toggled status", 1, 3'd3, 8'h00, 16'h1234, 0, 0, 0, 0);
    step("R3 array", 1, 3'd0, 8'h40, 16'hBEEF, 0, 0, 0, 0);
    step("R3 erase setup", 1, 3'd1, 8'h02, 16'hC0DE, 0, 0, 0, 0);
    step("R3 unused code", 1, 3'd6, 8'h02, 16'h5A5A, 0, 0, 0, 0);
    step("R4 manufacturer", 1, 3'd2, 8'h00, 16'h7777, 0, 0, 0, 0);
    step("R4 device", 1, 3'd2, 8'h02, 16'h7777, 0, 0, 0, 0);
    step("R4 protect", 1, 3'd2, 8'h04, 16'h7777, 0, 0, 0, 0);
    step("R2 odd byte offset", 1, 3'd2, 8'h03, 16'h7777, 0, 0, 0, 0);
    step("R5 ext id2", 1, 3'd2, 8'h1C, 16'h3333, 0, 0, 0, 0);
    step("R5 all-ones falls through", 1, 3'd2, 8'h1E, 16'h4444, 0, 0, 0, 0);
    step("R5 other index", 1, 3'd2, 8'h10, 16'h5555, 0, 0, 0, 0);
    step("R10 Q", 1, 3'd4, 8'h20, 16'h0, 0, 0, 0, 0);
    step("R10 R", 1, 3'd4, 8'h22, 16'h0, 0, 0, 0, 0);
    step("R10 Y", 1, 3'd4, 8'h24, 16'h0, 0, 0, 0, 0);
    step("R10 at limit", 1, 3'd4, 8'hA4, 16'h0, 0, 0, 0, 0);
    step("R10 above limit", 1, 3'd4, 8'hA6, 16'h0, 0, 0, 0, 0);
    step("R8 program start", 0, 3'd3, 8'h00, 16'h0, 1, 1, 0, 0);
    step("R8 status after program", 1, 3'd3, 8'h00, 16'h0, 0, 0, 0, 0);
    step("R9 done with read", 1, 3'd3, 8'h00, 16'h0, 0, 0, 0, 1);
    step("R9 status after done", 1, 3'd3, 8'h00, 16'h0, 0, 0, 0, 0);
    step("R7 erase over program", 0, 3'd0, 8'h00, 16'h0, 1, 0, 1, 0);
    step("R7 status after erase", 1, 3'd3, 8'h00, 16'h0, 0, 0, 0, 0);
    step("R11 idle", 0, 3'd0, 8'h00, 16'hFFFF, 0, 0, 0, 1);
    step("R9 status after lone done", 1, 3'd3, 8'h00, 16'h0, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] off = ($urandom % 4 == 0) ? 8'(($urandom % 3) * 2 + (($urandom % 2) ? 8'h1C : 8'h00))
                                            : 8'($urandom);
      step("R3-R10 random", ($urandom % 10) < 7, 3'($urandom), off, 16'($urandom),
           ($urandom % 20) == 0, 1'($urandom), ($urandom % 30) == 0, ($urandom % 20) == 0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule